// File: doc/BRIEF.md
# Time-Slot Test Pattern Generator and Checker

This block sits beside a time-slot switch and provides on-line testing of serial time-division highways. On the transmit side it watches a stream of outgoing time-slot bytes, each tagged with its highway number and slot number. On one chosen highway it replaces every byte whose slot lies inside a programmed window with a byte of test pattern. All other bytes pass through unchanged. On the receive side it watches incoming tagged bytes. On one chosen highway, inside a second window, it compares the data with the expected pattern and counts the bits that differ.

The patterns are a 2^15−1 pseudo-random sequence, a 2^20−1 pseudo-random sequence, a quasi-random variant of the 2^20−1 sequence with long zero runs suppressed, and fixed bytes (all zeros, all ones, or a software byte). The pseudo-random stream advances only on bytes inside the window, so successive frames form one continuous sequence. Bits are sent most significant first.

The receive checker first follows the incoming bits to load its sequence register. Once it has seen a run of matching bits it locks and runs freely, so each corrupted bit counts once. The error count saturates and is cleared when software reads it. Software can also force a single bit error into the generated stream to test the far-end checker.

Top module: `tdm_pattern_tester`

## Requirements
- R1: After reset, tx_valid_o, tx_ins_o, tx_data_o and rd_data_o are 0. The generator and checker are off, and the error count is 0.
- R2: Every tx_strobe_i produces tx_valid_o high one cycle later. A byte that is not replaced appears unchanged on tx_data_o in that cycle, with tx_ins_o low.
- R3: A byte is replaced, with tx_ins_o high, only under three conditions. The generator must be enabled (command register at address 8, bit 7). The byte's highway must equal the register at address 0. Its slot must satisfy lower ≤ slot ≤ upper, with lower at address 1 and upper at address 2. A lower bound above the upper bound gives an empty window.
- R4: Generator style 1 is selected by bits 7..4 of the style register at address 6. It yields the sequence of x^15+x^14+1: feedback is s[14]^s[13], the register shifts left, and the feedback bit is the output. The first bit of each byte goes to bit 7. Any write to address 8 reloads the state to all ones. The state advances only on replaced bytes.
- R5: Generator style 2 yields the sequence of x^20+x^17+1, with feedback s[19]^s[16], in the same bit order and with the same reseeding as R4.
- R6: Generator style 3 yields the R5 sequence, except that an output bit is forced to 1 whenever the 14 most recent register bits s[13:0] are all zero.
- R7: Fixed styles are as follows: style 0 sends 8'h00, style 4 sends the user byte at address 7, and styles 5 to 15 send 8'hFF.
- R8: A write to address 9 inverts bit 7 of the next replaced byte only. The bytes after it are unchanged.
- R9: Checker enable is bit 6 of address 8. Its highway is at address 3 and its window at addresses 4 (lower) and 5 (upper). Its style is in bits 3..0 of address 6, using the same codes as the generator. In styles 1 to 3 the checker shifts in received bits and counts nothing until LOCK_BITS consecutive bits match its prediction. A write to address 8 drops the lock.
- R10: Once locked, the checker adds one to the count for each mismatched bit in a window byte. Bytes outside the window, or on another highway, leave the count and the sequence untouched.
- R11: In the fixed styles the checker adds the number of bits that differ from the fixed byte, without needing lock.
- R12: The 16-bit error count saturates at 16'hFFFF.
- R13: A read of address 14 returns the low count byte one cycle after rd_en_i, latches the high byte and clears the count. A read of address 15 returns the latched high byte. rd_data_o is 0 when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Counter read strobe |
| rd_addr_i | input | 4 | Read address (14 low, 15 high) |
| rd_data_o | output | 8 | Read data, one cycle after rd_en_i |
| tx_strobe_i | input | 1 | Outgoing byte present |
| tx_hwy_i | input | HWY_W | Outgoing byte highway |
| tx_slot_i | input | SLOT_W | Outgoing byte slot |
| tx_data_i | input | 8 | Outgoing byte from the switch |
| tx_valid_o | output | 1 | Output byte present |
| tx_ins_o | output | 1 | Output byte is test pattern |
| tx_data_o | output | 8 | Output byte |
| rx_strobe_i | input | 1 | Incoming byte present |
| rx_hwy_i | input | HWY_W | Incoming byte highway |
| rx_slot_i | input | SLOT_W | Incoming byte slot |
| rx_data_i | input | 8 | Incoming byte |

## Verification
The embedded properties take for granted that configuration is written only while no byte strobes are active. They also assume the style is not changed while a pseudo-random check is running, since a style change would break the counter's no-count-before-lock property. The bench follows this: it writes every register between bursts with both strobes low. It also reseeds through the command register after each style change, before sending pattern bytes.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int SR_W  = 20;
  localparam int CNT_W = 16;

  localparam logic [3:0] STY_ZERO   = 4'd0;
  localparam logic [3:0] STY_PRBS15 = 4'd1;
  localparam logic [3:0] STY_PRBS20 = 4'd2;
  localparam logic [3:0] STY_QRSS   = 4'd3;
  localparam logic [3:0] STY_USER   = 4'd4;

  localparam logic [3:0] A_GHWY = 4'd0, A_GLO = 4'd1, A_GHI = 4'd2;
  localparam logic [3:0] A_CHWY = 4'd3, A_CLO = 4'd4, A_CHI = 4'd5;
  localparam logic [3:0] A_STY  = 4'd6, A_USER = 4'd7, A_CMD = 4'd8;
  localparam logic [3:0] A_INJ  = 4'd9, A_CNTL = 4'd14, A_CNTH = 4'd15;

  function automatic logic uses_lfsr(input logic [3:0] sty);
    return (sty == STY_PRBS15) || (sty == STY_PRBS20) || (sty == STY_QRSS);
  endfunction

  function automatic logic lfsr_fb(input logic [3:0] sty, input logic [SR_W-1:0] s);
    return (sty == STY_PRBS15) ? (s[14] ^ s[13]) : (s[19] ^ s[16]);
  endfunction

  function automatic logic pat_bit(input logic [3:0] sty, input logic [SR_W-1:0] s);
    return lfsr_fb(sty, s) | ((sty == STY_QRSS) && (s[13:0] == 14'd0));
  endfunction

  function automatic logic [7:0] fixed_byte(input logic [3:0] sty, input logic [7:0] user);
    if (sty == STY_ZERO) return 8'h00;
    else if (sty == STY_USER) return user;
    else return 8'hFF;
  endfunction
endpackage

// File: rtl/tpt_regs.sv
module tpt_regs
  import tpt_pkg::*;
#(
  parameter int HWY_W  = 5,
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [HWY_W-1:0]  g_hwy_o,
  output logic [SLOT_W-1:0] g_lo_o,
  output logic [SLOT_W-1:0] g_hi_o,
  output logic [HWY_W-1:0]  c_hwy_o,
  output logic [SLOT_W-1:0] c_lo_o,
  output logic [SLOT_W-1:0] c_hi_o,
  output logic [7:0]        style_o,
  output logic [7:0]        user_o,
  output logic              g_en_o,
  output logic              c_en_o,
  output logic              cmd_wr_o,
  output logic              inj_wr_o
);
  logic [HWY_W-1:0]  g_hwy_d, c_hwy_d;
  logic [SLOT_W-1:0] g_lo_d, g_hi_d, c_lo_d, c_hi_d;
  logic [7:0]        style_d, user_d;
  logic              g_en_d, c_en_d;

  always_comb begin
    g_hwy_d = g_hwy_o; g_lo_d = g_lo_o; g_hi_d = g_hi_o;
    c_hwy_d = c_hwy_o; c_lo_d = c_lo_o; c_hi_d = c_hi_o;
    style_d = style_o; user_d = user_o; g_en_d = g_en_o; c_en_d = c_en_o;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_GHWY: g_hwy_d = wr_data_i[HWY_W-1:0];
        A_GLO:  g_lo_d  = wr_data_i[SLOT_W-1:0];
        A_GHI:  g_hi_d  = wr_data_i[SLOT_W-1:0];
        A_CHWY: c_hwy_d = wr_data_i[HWY_W-1:0];
        A_CLO:  c_lo_d  = wr_data_i[SLOT_W-1:0];
        A_CHI:  c_hi_d  = wr_data_i[SLOT_W-1:0];
        A_STY:  style_d = wr_data_i;
        A_USER: user_d  = wr_data_i;
        A_CMD:  begin g_en_d = wr_data_i[7]; c_en_d = wr_data_i[6]; end
        default: ;
      endcase
    end
    cmd_wr_o = wr_en_i && (wr_addr_i == A_CMD);
    inj_wr_o = wr_en_i && (wr_addr_i == A_INJ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_hwy_o <= '0; g_lo_o <= '0; g_hi_o <= '0;
      c_hwy_o <= '0; c_lo_o <= '0; c_hi_o <= '0;
      style_o <= '0; user_o <= '0; g_en_o <= 1'b0; c_en_o <= 1'b0;
    end else begin
      g_hwy_o <= g_hwy_d; g_lo_o <= g_lo_d; g_hi_o <= g_hi_d;
      c_hwy_o <= c_hwy_d; c_lo_o <= c_lo_d; c_hi_o <= c_hi_d;
      style_o <= style_d; user_o <= user_d; g_en_o <= g_en_d; c_en_o <= c_en_d;
    end
  end
endmodule

// File: rtl/tpt_gen.sv
module tpt_gen
  import tpt_pkg::*;
#(
  parameter int HWY_W  = 5,
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [HWY_W-1:0]  hwy_i,
  input  logic [SLOT_W-1:0] lo_i,
  input  logic [SLOT_W-1:0] hi_i,
  input  logic [3:0]        style_i,
  input  logic [7:0]        user_i,
  input  logic              cmd_wr_i,
  input  logic              inj_wr_i,
  input  logic              tx_strobe_i,
  input  logic [HWY_W-1:0]  tx_hwy_i,
  input  logic [SLOT_W-1:0] tx_slot_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_valid_o,
  output logic              tx_ins_o,
  output logic [7:0]        tx_data_o
);
  logic [SR_W-1:0] state_q, state_d, walk;
  logic            inj_q, inj_d, hit;
  logic [7:0]      lbyte, pat, data_d;

  always_comb begin
    hit  = en_i && tx_strobe_i && (tx_hwy_i == hwy_i) &&
           (tx_slot_i >= lo_i) && (tx_slot_i <= hi_i);
    walk  = state_q;
    lbyte = '0;
    for (int i = 7; i >= 0; i--) begin
      lbyte[i] = pat_bit(style_i, walk);
      walk     = {walk[SR_W-2:0], lfsr_fb(style_i, walk)};
    end
    pat    = uses_lfsr(style_i) ? lbyte : fixed_byte(style_i, user_i);
    pat[7] = pat[7] ^ inj_q;
    state_d = state_q;
    if (cmd_wr_i) state_d = '1;
    else if (hit && uses_lfsr(style_i)) state_d = walk;
    inj_d  = inj_wr_i | (inj_q & ~hit);
    data_d = hit ? pat : tx_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1; inj_q <= 1'b0;
      tx_valid_o <= 1'b0; tx_ins_o <= 1'b0; tx_data_o <= '0;
    end else begin
      state_q <= state_d; inj_q <= inj_d;
      tx_valid_o <= tx_strobe_i; tx_ins_o <= hit; tx_data_o <= data_d;
    end
  end

  assert_ins_has_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ins_o |-> tx_valid_o);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o == $past(tx_strobe_i));
  assert_inject_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) && $past(inj_q) && !$past(inj_wr_i)) |-> !inj_q);
  assert_seed_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/tpt_chk.sv
module tpt_chk
  import tpt_pkg::*;
#(
  parameter int HWY_W     = 5,
  parameter int SLOT_W    = 7,
  parameter int LOCK_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [HWY_W-1:0]  hwy_i,
  input  logic [SLOT_W-1:0] lo_i,
  input  logic [SLOT_W-1:0] hi_i,
  input  logic [3:0]        style_i,
  input  logic [7:0]        user_i,
  input  logic              cmd_wr_i,
  input  logic              rd_clr_i,
  input  logic              rx_strobe_i,
  input  logic [HWY_W-1:0]  rx_hwy_i,
  input  logic [SLOT_W-1:0] rx_slot_i,
  input  logic [7:0]        rx_data_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int RUN_W = $clog2(LOCK_BITS + 1);

  logic [SR_W-1:0]  s_q, s_d, walk;
  logic [RUN_W-1:0] run_q, run_d, run;
  logic             lk_q, lk_d, lk, hit, lfsr_mode, e;
  logic [3:0]       nerr;
  logic [CNT_W-1:0] base, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    hit  = en_i && rx_strobe_i && (rx_hwy_i == hwy_i) &&
           (rx_slot_i >= lo_i) && (rx_slot_i <= hi_i);
    lfsr_mode = uses_lfsr(style_i);
    walk = s_q; run = run_q; lk = lk_q; nerr = '0; e = 1'b0;
    if (lfsr_mode) begin
      for (int i = 7; i >= 0; i--) begin
        e = pat_bit(style_i, walk);
        if (lk) begin
          if (rx_data_i[i] != e) nerr = nerr + 4'd1;
          walk = {walk[SR_W-2:0], lfsr_fb(style_i, walk)};
        end else begin
          if (rx_data_i[i] == e) begin
            if (run != RUN_W'(LOCK_BITS)) run = run + 1'b1;
          end else run = '0;
          walk = {walk[SR_W-2:0], rx_data_i[i]};
          if (run == RUN_W'(LOCK_BITS)) lk = 1'b1;
        end
      end
    end else begin
      nerr = 4'($countones(rx_data_i ^ fixed_byte(style_i, user_i)));
    end
    s_d = s_q; run_d = run_q; lk_d = lk_q;
    if (cmd_wr_i) begin
      s_d = '0; run_d = '0; lk_d = 1'b0;
    end else if (hit) begin
      s_d = walk; run_d = run; lk_d = lk;
    end
    base  = rd_clr_i ? '0 : count_o;
    sum   = {1'b0, base} + (hit ? (CNT_W+1)'(nerr) : '0);
    cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0; run_q <= '0; lk_q <= 1'b0; count_o <= '0;
    end else begin
      s_q <= s_d; run_q <= run_d; lk_q <= lk_d; count_o <= cnt_d;
    end
  end

  assert_count_mono_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_clr_i) |-> count_o >= $past(count_o));
  assert_count_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count_o) == '1 && !$past(rd_clr_i)) |-> count_o == '1);
  assert_no_count_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) && $past(lfsr_mode) && !$past(lk_q) && !$past(rd_clr_i))
      |-> count_o == $past(count_o));
  assert_clear_on_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_clr_i) && !$past(hit)) |-> count_o == '0);
endmodule

// File: rtl/tdm_pattern_tester.sv
module tdm_pattern_tester
  import tpt_pkg::*;
#(
  parameter int HWY_W     = 5,
  parameter int SLOT_W    = 7,
  parameter int LOCK_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  input  logic [3:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              tx_strobe_i,
  input  logic [HWY_W-1:0]  tx_hwy_i,
  input  logic [SLOT_W-1:0] tx_slot_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_valid_o,
  output logic              tx_ins_o,
  output logic [7:0]        tx_data_o,
  input  logic              rx_strobe_i,
  input  logic [HWY_W-1:0]  rx_hwy_i,
  input  logic [SLOT_W-1:0] rx_slot_i,
  input  logic [7:0]        rx_data_i
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [HWY_W-1:0]  g_hwy, c_hwy;
  logic [SLOT_W-1:0] g_lo, g_hi, c_lo, c_hi;
  logic [7:0]        style, user, snap_q, snap_d, rd_d;
  logic              g_en, c_en, cmd_wr, inj_wr, rd_clr;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  tpt_regs #(.HWY_W(HWY_W), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .g_hwy_o(g_hwy), .g_lo_o(g_lo), .g_hi_o(g_hi),
    .c_hwy_o(c_hwy), .c_lo_o(c_lo), .c_hi_o(c_hi), .style_o(style),
    .user_o(user), .g_en_o(g_en), .c_en_o(c_en), .cmd_wr_o(cmd_wr),
    .inj_wr_o(inj_wr));

  tpt_gen #(.HWY_W(HWY_W), .SLOT_W(SLOT_W)) u_gen (
    .clk(clk), .rst_n(rst_s), .en_i(g_en), .hwy_i(g_hwy), .lo_i(g_lo),
    .hi_i(g_hi), .style_i(style[7:4]), .user_i(user), .cmd_wr_i(cmd_wr),
    .inj_wr_i(inj_wr), .tx_strobe_i(tx_strobe_i), .tx_hwy_i(tx_hwy_i),
    .tx_slot_i(tx_slot_i), .tx_data_i(tx_data_i), .tx_valid_o(tx_valid_o),
    .tx_ins_o(tx_ins_o), .tx_data_o(tx_data_o));

  tpt_chk #(.HWY_W(HWY_W), .SLOT_W(SLOT_W), .LOCK_BITS(LOCK_BITS)) u_chk (
    .clk(clk), .rst_n(rst_s), .en_i(c_en), .hwy_i(c_hwy), .lo_i(c_lo),
    .hi_i(c_hi), .style_i(style[3:0]), .user_i(user), .cmd_wr_i(cmd_wr),
    .rd_clr_i(rd_clr), .rx_strobe_i(rx_strobe_i), .rx_hwy_i(rx_hwy_i),
    .rx_slot_i(rx_slot_i), .rx_data_i(rx_data_i), .count_o(count));

  always_comb begin
    rd_clr = rd_en_i && (rd_addr_i == A_CNTL);
    snap_d = rd_clr ? count[15:8] : snap_q;
    rd_d   = 8'h00;
    if (rd_en_i && rd_addr_i == A_CNTL) rd_d = count[7:0];
    else if (rd_en_i && rd_addr_i == A_CNTH) rd_d = snap_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      snap_q <= '0; rd_data_o <= '0;
    end else begin
      snap_q <= snap_d; rd_data_o <= rd_d;
    end
  end

  assert_rd_idle_zero_R13: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(rd_en_i) |-> rd_data_o == 8'h00);
endmodule

// File: tb/tdm_pattern_tester_tb.sv
module tdm_pattern_tester_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en_i, rd_en_i, tx_strobe_i, rx_strobe_i;
  logic [3:0] wr_addr_i, rd_addr_i;
  logic [7:0] wr_data_i, rd_data_o, tx_data_i, tx_data_o, rx_data_i;
  logic [4:0] tx_hwy_i, rx_hwy_i;
  logic [6:0] tx_slot_i, rx_slot_i;
  logic       tx_valid_o, tx_ins_o;

  int n_chk = 0, n_fail = 0;
  logic [19:0] ms;

  always #2 clk = ~clk;

  tdm_pattern_tester u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .tx_strobe_i(tx_strobe_i), .tx_hwy_i(tx_hwy_i),
    .tx_slot_i(tx_slot_i), .tx_data_i(tx_data_i), .tx_valid_o(tx_valid_o),
    .tx_ins_o(tx_ins_o), .tx_data_o(tx_data_o), .rx_strobe_i(rx_strobe_i),
    .rx_hwy_i(rx_hwy_i), .rx_slot_i(rx_slot_i), .rx_data_i(rx_data_i));

  // {hwy, slot, din, expected dout, expected insert}; window hwy 3, slots 5..9, user byte A5
  localparam logic [28:0] VEC [8] = '{
    {5'd3, 7'd5,  8'h11, 8'hA5, 1'b1},
    {5'd3, 7'd9,  8'h22, 8'hA5, 1'b1},
    {5'd3, 7'd4,  8'h33, 8'h33, 1'b0},
    {5'd3, 7'd10, 8'h44, 8'h44, 1'b0},
    {5'd2, 7'd7,  8'h55, 8'h55, 1'b0},
    {5'd3, 7'd7,  8'h66, 8'hA5, 1'b1},
    {5'd4, 7'd7,  8'h77, 8'h77, 1'b0},
    {5'd3, 7'd6,  8'h88, 8'hA5, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rd_data_o;
  endtask

  task automatic tx(input logic [4:0] h, input logic [6:0] s, input logic [7:0] d,
                    output logic [7:0] o, output logic ins, output logic v);
    @(negedge clk); tx_strobe_i = 1'b1; tx_hwy_i = h; tx_slot_i = s; tx_data_i = d;
    @(negedge clk); tx_strobe_i = 1'b0; o = tx_data_o; ins = tx_ins_o; v = tx_valid_o;
  endtask

  task automatic rx(input logic [4:0] h, input logic [6:0] s, input logic [7:0] d);
    @(negedge clk); rx_strobe_i = 1'b1; rx_hwy_i = h; rx_slot_i = s; rx_data_i = d;
    @(negedge clk); rx_strobe_i = 1'b0;
  endtask

  // serial pattern model written from R4..R6: first bit is bit 7
  task automatic model_byte(input logic [3:0] sty, output logic [7:0] b);
    logic fb;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      fb = (sty == 4'd1) ? (ms[14] ^ ms[13]) : (ms[19] ^ ms[16]);
      b[i] = fb | ((sty == 4'd3) && (ms[13:0] == 14'd0));
      ms = {ms[18:0], fb};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] o, e, d;
    logic ins, v;
    rst_n = 1'b0; wr_en_i = 0; rd_en_i = 0; tx_strobe_i = 0; rx_strobe_i = 0;
    wr_addr_i = 0; wr_data_i = 0; rd_addr_i = 0; tx_hwy_i = 0; tx_slot_i = 0;
    tx_data_i = 0; rx_hwy_i = 0; rx_slot_i = 0; rx_data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", tx_valid_o, 0);
    check("R1 tx_ins", tx_ins_o, 0);
    check("R1 tx_data", tx_data_o, 0);
    check("R1 rd_data", rd_data_o, 0);
    tx(5'd0, 7'd0, 8'h3C, o, ins, v);
    check("R1 gen off passthrough", {v, ins, o}, {2'b10, 8'h3C});
    rd(4'd14, d); check("R1 count zero", d, 0);

    // R2/R3/R7 table
    wr(4'd0, 8'd3); wr(4'd1, 8'd5); wr(4'd2, 8'd9);
    wr(4'd7, 8'hA5); wr(4'd6, 8'h40); wr(4'd8, 8'h80);
    foreach (VEC[k]) begin
      tx(VEC[k][28:24], VEC[k][23:17], VEC[k][16:9], o, ins, v);
      check("R3 window table data", o, VEC[k][8:1]);
      check("R2 window table flags", {v, ins}, {1'b1, VEC[k][0]});
    end
    wr(4'd6, 8'h00); tx(5'd3, 7'd6, 8'h12, o, ins, v);
    check("R7 style 0 zeros", o, 8'h00);
    wr(4'd6, 8'hF0); tx(5'd3, 7'd6, 8'h12, o, ins, v);
    check("R7 style 15 ones", o, 8'hFF);
    wr(4'd6, 8'h70); tx(5'd3, 7'd6, 8'h12, o, ins, v);
    check("R7 style 7 ones", o, 8'hFF);
    wr(4'd1, 8'd9); wr(4'd2, 8'd5); tx(5'd3, 7'd7, 8'h21, o, ins, v);
    check("R3 empty window", {ins, o}, {1'b0, 8'h21});

    // R4 PRBS15 over frames, window slots 0..3 on hwy 0
    wr(4'd0, 8'd0); wr(4'd1, 8'd0); wr(4'd2, 8'd3); wr(4'd6, 8'h10); wr(4'd8, 8'h80);
    ms = '1;
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 6; s++) begin
        tx(5'd0, 7'(s), 8'(8'h90 + s), o, ins, v);
        if (s <= 3) begin model_byte(4'd1, e); check("R4 prbs15 byte", {ins, o}, {1'b1, e}); end
        else check("R4 outside window untouched", {ins, o}, {1'b0, 8'(8'h90 + s)});
      end
    // R5 PRBS20
    wr(4'd6, 8'h20); wr(4'd8, 8'h80); ms = '1;
    for (int n = 0; n < 8; n++) begin
      tx(5'd0, 7'(n % 4), 8'h00, o, ins, v); model_byte(4'd2, e);
      check("R5 prbs20 byte", o, e);
    end
    // R6 QRSS and R8 injection
    wr(4'd6, 8'h30); wr(4'd8, 8'h80); ms = '1;
    for (int n = 0; n < 6; n++) begin
      tx(5'd0, 7'd1, 8'h00, o, ins, v); model_byte(4'd3, e);
      check("R6 qrss byte", o, e);
    end
    wr(4'd9, 8'h01);
    tx(5'd0, 7'd5, 8'h4D, o, ins, v);
    check("R8 no injection outside window", o, 8'h4D);
    tx(5'd0, 7'd2, 8'h00, o, ins, v); model_byte(4'd3, e);
    check("R8 injected bit 7", o, e ^ 8'h80);
    tx(5'd0, 7'd2, 8'h00, o, ins, v); model_byte(4'd3, e);
    check("R8 single injection", o, e);
    wr(4'd8, 8'h00); tx(5'd0, 7'd1, 8'h5E, o, ins, v);
    check("R2 disabled passthrough", {v, ins, o}, {2'b10, 8'h5E});

    // R9/R10 checker, PRBS15 on hwy 2 slots 0..3
    wr(4'd3, 8'd2); wr(4'd4, 8'd0); wr(4'd5, 8'd3); wr(4'd6, 8'h01); wr(4'd8, 8'h40);
    rx(5'd2, 7'd0, 8'hFF); rx(5'd2, 7'd1, 8'h3C);
    ms = 20'h0ACE1;
    for (int n = 0; n < 8; n++) begin model_byte(4'd1, e); rx(5'd2, 7'(n % 4), e); end
    rd(4'd14, d); check("R9 no count before lock", d, 0);
    rx(5'd1, 7'd0, 8'h00); rx(5'd2, 7'd4, 8'h00);
    model_byte(4'd1, e); rx(5'd2, 7'd0, e ^ 8'h08);
    model_byte(4'd1, e); rx(5'd2, 7'd1, e);
    model_byte(4'd1, e); rx(5'd2, 7'd2, e);
    rd(4'd14, d); check("R10 one error counted once", d, 8'd1);
    rd(4'd15, d); check("R13 high byte snapshot", d, 8'd0);
    rd(4'd14, d); check("R13 cleared by read", d, 8'd0);

    // R11 fixed byte
    wr(4'd7, 8'hA5); wr(4'd6, 8'h04); wr(4'd8, 8'h40);
    rx(5'd2, 7'd3, 8'hA4); rx(5'd2, 7'd3, 8'h5A); rx(5'd2, 7'd9, 8'h00);
    rd(4'd14, d); check("R11 fixed byte bit errors", d, 8'd9);

    // R12 saturation with all-ones style
    wr(4'd6, 8'h05);
    for (int n = 0; n < 8200; n++) rx(5'd2, 7'd0, 8'h00);
    rd(4'd14, d); check("R12 saturated low", d, 8'hFF);
    rd(4'd15, d); check("R12 saturated high", d, 8'hFF);
    rd(4'd14, d); check("R13 clear after saturation", d, 8'h00);
    rd(4'd15, d); check("R13 high snapshot after clear", d, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule